// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the two-wire management port of a clock generator. It lets a host read and write a bank of 8-bit configuration registers over SMBus. The block samples the bus clock and data lines with the system clock. It detects start and stop conditions and matches the 7-bit device address. It then takes an 8-bit command that selects one of two access styles.

When the top bit of the command is set, the access is a byte/word access. The low bits of the command name a register, and each further data byte moves on to the next register. When the top bit is clear, the access is a block access. It always starts at register 0. A write carries a byte count ahead of the data, and a read returns the bank size ahead of the data. For reads, the host first writes the command, then issues a repeated start with the read bit set. The block pulls the data line low only through an open-drain enable. It reaches the register bank through a simple address / write-strobe / read-data port.

Top module: `smb_reg_slave`

## Requirements
- R1: After a start condition, the slave checks the seven address bits and the direction bit (1 = read). When the address equals `SLAVE_ADDR`, it pulls SDA low during the ninth clock pulse.
- R2: When the address does not match, the slave never drives SDA and writes no register until the next start condition.
- R3: A command byte with bit 7 = 1 sets the register index to the command's low `IDX_W` bits. Each following data byte is written to the current index, and the index then steps by one, wrapping modulo `NUM_REGS`.
- R4: A command byte with bit 7 = 0 sets the index to 0. The next byte is a count, and the data bytes that follow are written to registers 0, 1, 2 and so on. Once count bytes have been written, any further data byte is neither acknowledged nor written.
- R5: The slave acknowledges every command byte and count byte, and every data byte it accepts.
- R6: After a byte/word command, a repeated start and a read address make the slave return the register at the index, then the following registers. Each byte is sent MSB first. After the master answers a byte with NACK, the slave stops driving.
- R7: After a block command, a read returns the byte count `NUM_REGS` first, then register 0, register 1 and so on.
- R8: The slave changes its SDA drive only while SCL is low. It releases SDA during the master's acknowledge slot on reads.
- R9: A stop or start condition at any point releases SDA at once and abandons the transfer. A partly received data byte is never written.
- R10: During and straight after reset, SDA is released and no write strobe is issued.
- R11: A register write is a one-cycle strobe, issued while the acknowledge for that byte is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | IDX_W (4) | Register index for both reads and writes |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Data for the register write |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` (combinational) |

## Verification
A level change on SCL or SDA passes through a two-stage synchronizer and one edge-compare stage. The drive enable and the write strobe are registered after that, so they move on the third clock edge after the bus edge that causes them. Each bus phase in the bench lasts six clocks. Every check of SDA, of the drive enable or of the register contents is taken at a falling system-clock edge, at least six clocks after the bus edge that triggers it, so the due cycle is always past. Monitors also flag any change of the drive enable while SCL is high, and any write strobe that is not paired with an acknowledge.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_COUNT,
        S_WDATA,
        S_RDATA,
        S_IGNORE
    } smb_state_e;

endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_prev;
        logic       sda_prev;
    } sense_s;

    sense_s q, d;

    always_comb begin
        d          = q;
        d.scl_sync = {q.scl_sync[0], scl_i};
        d.sda_sync = {q.sda_sync[0], sda_i};
        d.scl_prev = q.scl_sync[1];
        d.sda_prev = q.sda_sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = q.sda_sync[1];
    assign scl_rise_o = q.scl_sync[1] & ~q.scl_prev;
    assign scl_fall_o = ~q.scl_sync[1] & q.scl_prev;
    // a data edge while the clock stays high marks a bus condition
    assign start_o    = q.scl_sync[1] & q.scl_prev & q.sda_prev & ~q.sda_sync[1];
    assign stop_o     = q.scl_sync[1] & q.scl_prev & ~q.sda_prev & q.sda_sync[1];

endmodule

// File: rtl/smb_slave_core.sv
module smb_slave_core
    import smb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         NUM_REGS   = 16,
    parameter int         IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              sda_oe_o,
    output logic [IDX_W-1:0]  reg_addr_o,
    output logic              reg_wr_o,
    output logic [BYTE_W-1:0] reg_wdata_o
);

    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);
    localparam logic [3:0]        LAST_BIT   = 4'd8;
    localparam logic [3:0]        ACK_SLOT   = 4'd9;

    typedef struct packed {
        smb_state_e        state;
        smb_state_e        nxt;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] tx;
        logic [IDX_W-1:0]  idx;
        logic              blk;
        logic              first;
        logic              nack;
        logic [BYTE_W-1:0] remain;
        logic              oe;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } core_s;

    core_s q, d;

    function automatic core_s load_byte(core_s s, logic [BYTE_W-1:0] rd);
        core_s r = s;
        if (s.blk && s.first) begin
            r.tx    = COUNT_BYTE;
            r.first = 1'b0;
        end else begin
            r.tx  = rd;
            r.idx = s.idx + 1'b1;
        end
        r.oe    = ~r.tx[BYTE_W-1];
        r.cnt   = '0;
        r.nack  = 1'b0;
        r.state = S_RDATA;
        return r;
    endfunction

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (q.wr) d.idx = q.idx + 1'b1;

        if (stop_i) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (start_i) begin
            d.state = S_ADDR;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (q.state == S_RDATA) begin
            if (scl_rise_i) begin
                if (q.cnt < LAST_BIT)      d.cnt  = q.cnt + 4'd1;
                else if (q.cnt == ACK_SLOT) d.nack = sda_i;
            end
            if (scl_fall_i) begin
                if (q.cnt == LAST_BIT) begin
                    d.oe  = 1'b0;
                    d.cnt = ACK_SLOT;
                end else if (q.cnt == ACK_SLOT) begin
                    if (q.nack) begin
                        d.state = S_IGNORE;
                        d.oe    = 1'b0;
                    end else begin
                        d = load_byte(d, reg_rdata_i);
                    end
                end else begin
                    d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                    d.oe = ~q.tx[BYTE_W-2];
                end
            end
        end else if (q.state inside {S_ADDR, S_CMD, S_COUNT, S_WDATA}) begin
            if (scl_rise_i && q.cnt < LAST_BIT) begin
                d.shift = {q.shift[BYTE_W-2:0], sda_i};
                d.cnt   = q.cnt + 4'd1;
            end
            if (scl_fall_i && q.cnt == LAST_BIT) begin
                d.cnt = ACK_SLOT;
                case (q.state)
                    S_ADDR: begin
                        if (q.shift[7:1] == SLAVE_ADDR) begin
                            d.oe    = 1'b1;
                            d.first = 1'b1;
                            d.nxt   = q.shift[0] ? S_RDATA : S_CMD;
                        end else begin
                            d.state = S_IGNORE;
                            d.cnt   = '0;
                        end
                    end
                    S_CMD: begin
                        d.oe  = 1'b1;
                        d.blk = ~q.shift[7];
                        d.idx = q.shift[7] ? q.shift[IDX_W-1:0] : '0;
                        d.nxt = q.shift[7] ? S_WDATA : S_COUNT;
                    end
                    S_COUNT: begin
                        d.oe     = 1'b1;
                        d.remain = q.shift;
                        d.nxt    = S_WDATA;
                    end
                    default: begin
                        if (!q.blk || q.remain != '0) begin
                            d.oe     = 1'b1;
                            d.wr     = 1'b1;
                            d.wdata  = q.shift;
                            d.remain = q.blk ? q.remain - 1'b1 : q.remain;
                            d.nxt    = S_WDATA;
                        end else begin
                            d.state = S_IGNORE;
                            d.cnt   = '0;
                        end
                    end
                endcase
            end else if (scl_fall_i && q.cnt == ACK_SLOT) begin
                d.oe    = 1'b0;
                d.cnt   = '0;
                d.state = q.nxt;
                if (q.nxt == S_RDATA) d = load_byte(d, reg_rdata_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o    = q.oe;
    assign reg_addr_o  = q.idx;
    assign reg_wr_o    = q.wr;
    assign reg_wdata_o = q.wdata;

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         NUM_REGS   = 16,
    localparam int        IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [IDX_W-1:0]  reg_addr_o,
    output logic              reg_wr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    logic sda_w, rise_w, fall_w, start_w, stop_w;

    smb_line_sense sense_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_w),
        .scl_rise_o (rise_w),
        .scl_fall_o (fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    smb_slave_core #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .NUM_REGS   (NUM_REGS),
        .IDX_W      (IDX_W)
    ) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_i       (sda_w),
        .scl_rise_i  (rise_w),
        .scl_fall_i  (fall_w),
        .start_i     (start_w),
        .stop_i      (stop_w),
        .reg_rdata_i (reg_rdata_i),
        .sda_oe_o    (sda_oe_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wr_o    (reg_wr_o),
        .reg_wdata_o (reg_wdata_o)
    );

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic reg_wr_o,
    input logic start_w,
    input logic stop_w
);

    AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> sda_oe_o);                                            // R11
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);                                           // R11
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);                  // R8
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (!sda_oe_o && !reg_wr_o));                              // R9
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !sda_oe_o);                                            // R9

endmodule

bind smb_reg_slave smb_reg_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .reg_wr_o (reg_wr_o),
    .start_w  (start_w),
    .stop_w   (stop_w)
);

// File: tb/smb_reg_slave_tb.sv
module smb_reg_slave_tb_top;

    localparam int         N   = 16;
    localparam int         IW  = 4;
    localparam int         Q   = 6;
    localparam logic [6:0] ADR = 7'h69;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          oe;
    logic [IW-1:0] addr;
    logic          wr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;
    logic [7:0]    rf  [N];
    logic [7:0]    exp_rf [N];
    int            checks = 0;
    int            fails  = 0;
    int            oe_high_scl = 0;
    int            wr_no_ack = 0;
    int            oe_cycles = 0;
    logic          oe_prev = 1'b0;

    wire sda_line = sda_m & ~oe;

    always #5 clk = ~clk;

    smb_reg_slave #(.SLAVE_ADDR(ADR), .NUM_REGS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(oe), .reg_addr_o(addr), .reg_wr_o(wr),
        .reg_wdata_o(wdata), .reg_rdata_i(rdata)
    );

    assign rdata = rf[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rf[i] <= 8'hF0 ^ 8'(i);
        end else if (wr) begin
            rf[addr] <= wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (oe != oe_prev && scl) oe_high_scl++;
            if (wr && !oe) wr_no_ack++;
            if (oe) oe_cycles++;
        end
        oe_prev = oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic half();
        repeat (Q) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half(); scl = 1'b1; half();
        sda_m = 1'b0; half(); scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half(); scl = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_m = b; half(); scl = 1'b1; half();
        @(negedge clk); r = sda_line;
        half(); scl = 1'b0; half();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic r;
        for (int k = 7; k >= 0; k--) bit_xfer(v[k], r);
        bit_xfer(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic m_ack, output logic [7:0] v);
        logic r;
        v = '0;
        for (int k = 0; k < 8; k++) begin
            bit_xfer(1'b1, r);
            v = {v[6:0], r};
        end
        sda_m = ~m_ack; half(); scl = 1'b1; half();
        @(negedge clk);
        chk(!oe, "R8 released in master ack slot", int'(oe), 0);
        half(); scl = 1'b0; half();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] v;
        for (int i = 0; i < N; i++) exp_rf[i] = 8'hF0 ^ 8'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!oe && !wr, "R10 reset state", int'({oe, wr}), 0);
        rst_n = 1'b1;
        half();
        @(negedge clk);
        chk(!oe && !wr, "R10 after reset", int'({oe, wr}), 0);

        // R3 byte writes to every index
        for (int i = 0; i < N; i++) begin
            v = 8'(i * 37 + 5);
            bus_start();
            wbyte({ADR, 1'b0}, a); chk(a, "R1 address ack", int'(a), 1);
            wbyte(8'h80 | 8'(i), a); chk(a, "R5 command ack", int'(a), 1);
            wbyte(v, a); chk(a, "R5 data ack", int'(a), 1);
            bus_stop();
            exp_rf[i] = v;
            chk(rf[i] == exp_rf[i], "R3 byte write", int'(rf[i]), int'(exp_rf[i]));
        end

        // R3 word write with wrap, and upper command bits ignored
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'h8F, a); wbyte(8'h11, a); wbyte(8'h22, a);
        bus_stop();
        exp_rf[15] = 8'h11; exp_rf[0] = 8'h22;
        chk(rf[15] == 8'h11, "R3 word first", int'(rf[15]), 'h11);
        chk(rf[0] == 8'h22, "R3 word wrap", int'(rf[0]), 'h22);
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'hF3, a); wbyte(8'h5C, a);
        bus_stop();
        exp_rf[3] = 8'h5C;
        chk(rf[3] == 8'h5C, "R3 low bits index", int'(rf[3]), 'h5C);

        // R6 byte reads from every index
        for (int i = 0; i < N; i++) begin
            bus_start();
            wbyte({ADR, 1'b0}, a); wbyte(8'h80 | 8'(i), a);
            bus_start();
            wbyte({ADR, 1'b1}, a); chk(a, "R1 read address ack", int'(a), 1);
            rbyte(1'b0, v);
            chk(v == exp_rf[i], "R6 byte read", int'(v), int'(exp_rf[i]));
            @(negedge clk);
            chk(!oe, "R6 released after NACK", int'(oe), 0);
            bus_stop();
        end

        // R6 word read across the wrap
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'h8F, a);
        bus_start();
        wbyte({ADR, 1'b1}, a);
        rbyte(1'b1, v); chk(v == exp_rf[15], "R6 word first", int'(v), int'(exp_rf[15]));
        rbyte(1'b0, v); chk(v == exp_rf[0], "R6 word wrap", int'(v), int'(exp_rf[0]));
        bus_stop();

        // R4 block write with over-count byte
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'h00, a);
        wbyte(8'd3, a); chk(a, "R5 count ack", int'(a), 1);
        for (int k = 0; k < 3; k++) begin
            wbyte(8'hA0 + 8'(k), a); chk(a, "R4 block data ack", int'(a), 1);
            exp_rf[k] = 8'hA0 + 8'(k);
        end
        wbyte(8'hA3, a); chk(!a, "R4 over-count nack", int'(a), 0);
        bus_stop();
        for (int k = 0; k < 4; k++)
            chk(rf[k] == exp_rf[k], "R4 block contents", int'(rf[k]), int'(exp_rf[k]));

        // R7 block read
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'h00, a);
        bus_start();
        wbyte({ADR, 1'b1}, a);
        rbyte(1'b1, v); chk(v == 8'(N), "R7 count byte", int'(v), N);
        for (int k = 0; k < N; k++) begin
            rbyte(k != N - 1, v);
            chk(v == exp_rf[k], "R7 block data", int'(v), int'(exp_rf[k]));
        end
        bus_stop();

        // R9 stop in the middle of a data byte
        bus_start();
        wbyte({ADR, 1'b0}, a); wbyte(8'h84, a);
        for (int k = 0; k < 4; k++) bit_xfer(k[0], a);
        bus_stop();
        half();
        @(negedge clk);
        chk(rf[4] == exp_rf[4], "R9 partial byte dropped", int'(rf[4]), int'(exp_rf[4]));
        chk(!oe, "R9 released after stop", int'(oe), 0);

        // R2 address mismatch
        oe_cycles = 0;
        bus_start();
        wbyte({7'h12, 1'b0}, a); chk(!a, "R2 no ack", int'(a), 0);
        wbyte(8'h82, a); wbyte(8'hAA, a);
        bus_stop();
        chk(oe_cycles == 0, "R2 never drives", oe_cycles, 0);
        chk(rf[2] == exp_rf[2], "R2 no write", int'(rf[2]), int'(exp_rf[2]));

        chk(oe_high_scl == 0, "R8 drive changes with SCL low", oe_high_scl, 0);
        chk(wr_no_ack == 0, "R11 strobe with ack", wr_no_ack, 0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule